// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a watchdog with a lower bound as well as an upper bound on when software may service it. A 7-bit down-counter steps once per prescaled tick. Software must reload it after it has fallen below a programmed window value and before it passes from 0x40 to 0x3F. Reloading too late, reloading too early, or loading a value without bit 6 set all raise a one-cycle system reset request once the watchdog is armed. An early-warning flag is set when the counter lands on 0x40. It can be routed to an interrupt line, which gives software a last chance to reload.

Software reaches the block through three write strobes that share one data bus: control, configuration and status. The current state is visible on plain read-out ports. The tick period is `PRE_BASE` input cycles, times 1, 2, 4 or 8 as picked by the timebase field. The prescaler restarts on every control write.

Top module: `wdog_window`

## Requirements
- R1: After reset the counter reads 0x7F, the window reads 0x7F, the timebase reads 0, and the armed bit, early-warning flag, interrupt enable, interrupt and reset request all read 0.
- R2: With timebase TB (configuration bits 8:7), the counter decrements once every `PRE_BASE`·2^TB cycles. The prescaler restarts on each control write, so the first decrement comes exactly one full period after that write.
- R3: A control write with data bit 7 = 1 arms the watchdog. A control write with bit 7 = 0 never disarms it; only reset does.
- R4: While armed, the step of the counter from 0x40 to 0x3F raises `rst_req_o` for exactly one cycle, in the cycle the counter shows 0x3F.
- R5: While armed, a control write whose counter value (data bits 6:0) has bit 6 = 0 raises `rst_req_o` in the cycle after the write.
- R6: While armed, a control write made while the counter is greater than or equal to the window raises `rst_req_o` in the cycle after the write.
- R7: While armed, a control write made while the counter is below the window and whose value has bit 6 = 1 raises no reset request.
- R8: The early-warning flag is set when a decrement brings the counter to 0x40, whether or not the interrupt is enabled.
- R9: A status write with data bit 0 = 0 clears the flag; a status write with bit 0 = 1 leaves it unchanged.
- R10: The interrupt enable (configuration bit 9) is set by writing 1 and is cleared only by reset. `irq_o` is high whenever the flag and the enable are both set.
- R11: While disarmed, no reset request is ever raised, and the counter still decrements.
- R12: A control write in the same cycle as a decrement tick wins: the counter takes the written value.
- R13: A configuration write loads the window from data bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ctl | input | 1 | Control write strobe (bit 7 arm, bits 6:0 counter) |
| wr_cfg | input | 1 | Configuration write strobe (bit 9 irq enable, bits 8:7 timebase, bits 6:0 window) |
| wr_sts | input | 1 | Status write strobe (bit 0 = 0 clears the flag) |
| wr_data | input | 10 | Write data shared by the strobes |
| cnt_o | output | 7 | Current counter value |
| win_o | output | 7 | Window value |
| tb_o | output | 2 | Timebase selector |
| armed_o | output | 1 | Watchdog armed |
| ewi_en_o | output | 1 | Early-warning interrupt enable |
| flag_o | output | 1 | Early-warning flag |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Every register result is due one clock after its cause. A write shows in the read-out ports and in `rst_req_o` in the cycle after the strobe edge. A decrement shows exactly `PRE_BASE`·2^TB edges after the last control write or tick. The flag appears together with the counter value 0x40, and the 0x40-to-0x3F reset pulse appears together with 0x3F. The bench drives inputs on the falling edge and samples all outputs on the next falling edge, so each sample sees exactly one rising edge's worth of effect. Directed waits are counted in whole periods to hit the decrement cycle, and the cycle before it. A requirement-level model, stepped on the same edges, is compared on every falling edge through directed and random phases.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int PRE_BASE = 4096,
  parameter int CNT_W    = 7,
  parameter int TB_W     = 2,
  parameter int DATA_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_cfg,
  input  logic              wr_sts,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  win_o,
  output logic [TB_W-1:0]   tb_o,
  output logic              armed_o,
  output logic              ewi_en_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int PRE_W = $clog2(PRE_BASE) + (1 << TB_W) + 1;
  localparam logic [CNT_W-1:0] CNT_INIT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_WARN = CNT_W'(1) << (CNT_W - 1);
  localparam int ARM_BIT = CNT_W;
  localparam int TB_LSB  = CNT_W;
  localparam int EWI_BIT = CNT_W + TB_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_lim;
  logic [CNT_W-1:0] cnt_q, win_q;
  logic [TB_W-1:0]  tb_q;
  logic             arm_q, ewi_q, flag_q, rreq_q;
  logic             tick, dec, early, bad_val;

  assign pre_lim = PRE_W'(PRE_BASE) << tb_q;
  assign tick    = (pre_q == pre_lim - 1'b1);
  assign dec     = tick && !wr_ctl;
  assign early   = (cnt_q >= win_q);
  assign bad_val = !wr_data[CNT_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 pre_q <= '0;
    else if (wr_ctl || tick)    pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt_q <= CNT_INIT;
    else if (wr_ctl) cnt_q <= wr_data[CNT_W-1:0];
    else if (tick)   cnt_q <= cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm_q <= 1'b0;
      ewi_q <= 1'b0;
      win_q <= CNT_INIT;
      tb_q  <= '0;
    end else begin
      if (wr_ctl && wr_data[ARM_BIT]) arm_q <= 1'b1;
      if (wr_cfg) begin
        win_q <= wr_data[CNT_W-1:0];
        tb_q  <= wr_data[TB_LSB +: TB_W];
        if (wr_data[EWI_BIT]) ewi_q <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          flag_q <= 1'b0;
    else if (dec && cnt_q == CNT_WARN + 1'b1) flag_q <= 1'b1;
    else if (wr_sts && !wr_data[0])      flag_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rreq_q <= 1'b0;
    else        rreq_q <= arm_q && ((dec && cnt_q == CNT_WARN) ||
                                    (wr_ctl && (bad_val || early)));

  assign cnt_o     = cnt_q;
  assign win_o     = win_q;
  assign tb_o      = tb_q;
  assign armed_o   = arm_q;
  assign ewi_en_o  = ewi_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q && ewi_q;
  assign rst_req_o = rreq_q;

  // R3: arming is sticky
  p_arm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> arm_q);
  // R10: interrupt enable is sticky
  p_ewi_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ewi_q |=> ewi_q);
  // R11: no request unless armed
  p_req_armed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |-> arm_q);
  // R2: without a write the counter only ever steps down by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctl && cnt_q != CNT_INIT - 1'b1 + 1'b1) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  // R8: the flag rises only with the counter at the warning value
  p_flag_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> cnt_q == CNT_WARN);
  // R4: a request needs a write or the warning-to-below step
  p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |-> ($past(wr_ctl) || ($past(cnt_q) == CNT_WARN && cnt_q == CNT_WARN - 1'b1)));
endmodule

// File: tb/wdog_window_bench.sv
`timescale 1ns/1ps
module wdog_window_bench;
  localparam int PB = 4;
  logic clk = 0, rst_n = 0;
  logic wr_ctl = 0, wr_cfg = 0, wr_sts = 0;
  logic [9:0] wr_data = '0;
  logic [6:0] cnt_o, win_o;
  logic [1:0] tb_o;
  logic armed_o, ewi_en_o, flag_o, irq_o, rst_req_o;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_window #(.PRE_BASE(PB)) u_wdog_window (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_cfg(wr_cfg), .wr_sts(wr_sts),
    .wr_data(wr_data), .cnt_o(cnt_o), .win_o(win_o), .tb_o(tb_o), .armed_o(armed_o),
    .ewi_en_o(ewi_en_o), .flag_o(flag_o), .irq_o(irq_o), .rst_req_o(rst_req_o));

  // requirement-level model, stepped on the same edges
  int m_pre; logic [6:0] m_cnt, m_win; logic [1:0] m_tb;
  logic m_arm, m_ewi, m_flag, m_req;
  function automatic int period(input logic [1:0] tb); return PB << tb; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 7'h7F; m_win = 7'h7F; m_tb = 0;
      m_arm = 0; m_ewi = 0; m_flag = 0; m_req = 0;
    end else begin
      automatic bit tk = (m_pre == period(m_tb) - 1);
      automatic logic [6:0] c = m_cnt;
      m_req = 0;
      if (wr_ctl) begin
        if (m_arm && (!wr_data[6] || c >= m_win)) m_req = 1;
        m_cnt = wr_data[6:0]; m_pre = 0;
        if (wr_data[7]) m_arm = 1;
      end else if (tk) begin
        m_pre = 0;
        if (m_arm && c == 7'h40) m_req = 1;
        if (c == 7'h41) m_flag = 1;
        else if (wr_sts && !wr_data[0]) m_flag = 0;
        m_cnt = c - 1;
      end else m_pre = m_pre + 1;
      if (!(!wr_ctl && tk && c == 7'h41) && wr_sts && !wr_data[0]) m_flag = 0;
      if (wr_cfg) begin
        m_win = wr_data[6:0]; m_tb = wr_data[8:7];
        if (wr_data[9]) m_ewi = 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // continuous model comparison
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2/R12 model cnt", cnt_o, m_cnt);
    chk("R4/R5/R6/R7/R11 model req", rst_req_o, m_req);
    chk("R8/R9 model flag", flag_o, m_flag);
    chk("R10 model irq", irq_o, m_flag && m_ewi);
    chk("R3 model armed", armed_o, m_arm);
    chk("R13 model window", win_o, m_win);
  end

  task automatic wctl(input logic [9:0] d);
    wr_ctl = 1; wr_data = d; @(negedge clk); wr_ctl = 0; wr_data = '0;
  endtask
  task automatic wcfg(input logic [9:0] d);
    wr_cfg = 1; wr_data = d; @(negedge clk); wr_cfg = 0; wr_data = '0;
  endtask
  task automatic wsts(input logic [9:0] d);
    wr_sts = 1; wr_data = d; @(negedge clk); wr_sts = 0; wr_data = '0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  initial begin
    int sawreq;
    void'($urandom(32'd1234));
    idle(2); rst_n = 1; @(negedge clk);
    chk("R1 cnt", cnt_o, 7'h7F); chk("R1 win", win_o, 7'h7F); chk("R1 tb", tb_o, 0);
    chk("R1 armed", armed_o, 0); chk("R1 flag", flag_o, 0); chk("R1 ewi", ewi_en_o, 0);
    chk("R1 req", rst_req_o, 0); chk("R1 irq", irq_o, 0);

    // R11: disarmed counting through 0x40 without request
    wctl(10'h041);
    sawreq = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (rst_req_o) sawreq = 1; end
    chk("R11 cnt still decrements", cnt_o, 7'h3F);
    chk("R11 no request", sawreq, 0);
    chk("R8 flag without irq enable", flag_o, 1);
    chk("R10 irq masked", irq_o, 0);
    wsts(10'h001); chk("R9 write 1 ignored", flag_o, 1);
    wsts(10'h000); chk("R9 write 0 clears", flag_o, 0);

    // config window 0x50, tb 1, irq enable; arm
    wcfg(10'h200 | 10'h080 | 10'h050);
    chk("R13 window", win_o, 7'h50); chk("R2 tb", tb_o, 1); chk("R10 ewi set", ewi_en_o, 1);
    wctl(10'h0FF);
    chk("R3 armed", armed_o, 1); chk("R6 arming write not checked", rst_req_o, 0);
    idle(7); chk("R2 no step before period", cnt_o, 7'h7F);
    idle(1); chk("R2 step at period 8", cnt_o, 7'h7E);

    wctl(10'h07F); chk("R6 early reload", rst_req_o, 1);
    chk("R3 bit7=0 keeps armed", armed_o, 1);
    idle(1); chk("R4 single-cycle pulse", rst_req_o, 0);
    wctl(10'h0B0); chk("R5 value below 0x40", rst_req_o, 1);
    wctl(10'h045); chk("R7 reload in window", rst_req_o, 0);
    wcfg(10'h080 | 10'h045);
    wctl(10'h060); chk("R6 equal to window is early", rst_req_o, 1);

    wcfg(10'h07F);
    chk("R10 ewi not cleared by write 0", ewi_en_o, 1);
    wctl(10'h042); chk("R7 ok reload", rst_req_o, 0);
    idle(4); chk("R2 period 4", cnt_o, 7'h41);
    idle(3); chk("R8 flag not yet", flag_o, 0);
    idle(1); chk("R8 flag at 0x40", flag_o, 1); chk("R10 irq", irq_o, 1);
    idle(3); chk("R4 no request yet", rst_req_o, 0);
    idle(1); chk("R4 cnt 0x3F", cnt_o, 7'h3F); chk("R4 request", rst_req_o, 1);
    idle(1); chk("R4 pulse ends", rst_req_o, 0);

    wctl(10'h070); idle(3);
    wctl(10'h065); chk("R12 write beats tick", cnt_o, 7'h65);
    idle(3); chk("R12 prescaler restarted", cnt_o, 7'h65);
    idle(1); chk("R12 next step", cnt_o, 7'h64);
    wsts(10'h000); chk("R10 irq drops with flag", irq_o, 0);

    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      logic [9:0] d = 10'($urandom);
      if (r < 4) begin
        if ($urandom_range(0, 3) != 0) d[6] = 1;
        wctl(d);
      end else if (r < 6) begin
        d[6:0] = 7'($urandom_range(64, 127)); wcfg(d);
      end else if (r < 9) wsts(d);
      else @(negedge clk);
    end
    finish_run();
  end
endmodule